// File: doc/BRIEF.md
# Delayed Write Completion Queue

This block sits on the target side of a bus bridge. It keeps a short first-in, first-out list of delayed single-DWORD write transactions. Each entry holds an address, a command code, active-low byte enables and one DWORD of data. The first attempt of a write that is not yet in the list takes a free slot and is told to retry. The far side of the bridge reads the oldest undelivered entry from the execute outputs and pulses a completion strobe once that write has been delivered.

When the initiator repeats a write, the attempt is compared with every queued entry. The address, the command and the byte enables must be equal, and the data must be equal in the enabled byte lanes. A repeat that finds its entry still undelivered is retried again. A repeat that finds its entry delivered and at the head of the list is accepted as a data transfer, and it is disconnected if the initiator asked for more than one DWORD. A completion that nobody collects is aged out by a head-of-list timer. The timer is loaded from a programmable value. When it expires, a system-error pulse is raised if that pulse is enabled.

Top module: `dlyw_queue`

## Requirements
- R1: While reset is held, and in the first cycle after it, rsp_valid, rsp_retry, rsp_xfer, rsp_stop, serr_pulse and exec_valid are all 0.
- R2: Each attempt (att_valid high for one cycle) is answered exactly one cycle later with a one-cycle rsp_valid. An attempt that matches no entry while fewer than DEPTH entries are held is answered with rsp_retry=1 and rsp_xfer=0. It is appended to the list, and it appears on the exec outputs once every older entry has been delivered.
- R3: An attempt that matches no entry while DEPTH entries are held is answered with retry and is not stored. The list never holds more than DEPTH entries.
- R4: A repeat that matches an undelivered entry is answered with retry and adds no entry.
- R5: An attempt matches an entry only if the address, the command and att_ben are all equal, and data bits [8i+7:8i] are equal for every lane i with att_ben[i]=0 (0 enables the lane). A difference in a lane with att_ben[i]=1 does not prevent a match.
- R6: A cpl_valid pulse marks the oldest undelivered entry as delivered. The exec outputs then move to the next undelivered entry in arrival order. exec_valid is 0 when no entry is undelivered.
- R7: A repeat that matches the delivered head entry is answered with rsp_xfer=1 and rsp_retry=0, with rsp_stop equal to att_multi. The entry is then freed.
- R8: A repeat that matches a delivered entry that is not the head is answered with retry and leaves the entry in place.
- R9: Let the first clock edge at which the head entry is seen delivered load the timer with value L (discard_load). If the entry is not collected, it is removed from the list at the edge L+1 cycles after that loading edge.
- R10: A removal by the timer gives a one-cycle serr_pulse in the cycle after the removing edge, provided serr_en was 1 at that edge. In every other case serr_pulse stays 0.
- R11: After a collection or a removal, the timer loads afresh for the next delivered head entry. A collection at the same edge as an expiry takes precedence, and no error pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| att_valid | input | 1 | Write attempt present this cycle |
| att_addr | input | AW | Attempt address |
| att_cmd | input | CW | Attempt command code |
| att_ben | input | DW/8 | Attempt byte enables, active low |
| att_data | input | DW | Attempt write data |
| att_multi | input | 1 | Initiator requests more than one DWORD |
| cpl_valid | input | 1 | Far side delivered the oldest undelivered entry |
| discard_load | input | TW | Timer load value |
| serr_en | input | 1 | Enables the system-error pulse |
| rsp_valid | output | 1 | Response to the attempt of the previous cycle |
| rsp_retry | output | 1 | Response is target retry |
| rsp_xfer | output | 1 | Response is a data transfer (completion collected) |
| rsp_stop | output | 1 | Disconnect given with the transfer |
| serr_pulse | output | 1 | Completion discarded by the timer |
| exec_valid | output | 1 | An undelivered entry is waiting for the far side |
| exec_addr | output | AW | Address of that entry |
| exec_cmd | output | CW | Command of that entry |
| exec_ben | output | DW/8 | Byte enables of that entry |
| exec_data | output | DW | Data of that entry |

## Verification
If a stored field or the lane masking is wrong, a repeat that should collect is retried instead, or an unrelated write shows up on the exec outputs. Either error appears in the response one cycle after the attempt, or on the exec outputs as soon as the older entries have been delivered. A slip in the head, tail or execute pointer shows up as a wrong entry on the exec outputs after the next completion strobe. An off-by-one in the timer moves the error pulse, and the freeing of the head entry, by a cycle; so does a timer that fails to restart, which is visible within L+2 cycles. The bench runs a behavioural model beside the block and compares every output on every cycle. It does this through directed sequences and through random traffic drawn from a small pool of writes.

// File: rtl/dlyw_pkg.sv
// Shared types for the delayed write queue.
// Assumes: nothing beyond IEEE 1800-2017.
package dlyw_pkg;

    // What the current attempt does to the list.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_QUEUE   = 2'd1,
        ACT_COLLECT = 2'd2,
        ACT_HOLD    = 2'd3
    } dlyw_act_t;

    // Registered answer to an attempt.
    typedef struct packed {
        logic vld;
        logic retry;
        logic xfer;
        logic stop;
    } dlyw_rsp_t;

endpackage

// File: rtl/dlyw_slot_cmp.sv
// Compares one queued entry against the current attempt.
// The address, command and byte enables must be equal, and the data is
// compared only in lanes whose active-low enable is 0.
// Assumes: DW is a multiple of 8.
module dlyw_slot_cmp #(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          slot_vld,
    input  logic [AW-1:0] slot_addr,
    input  logic [CW-1:0] slot_cmd,
    input  logic [BW-1:0] slot_ben,
    input  logic [DW-1:0] slot_data,
    input  logic [AW-1:0] att_addr,
    input  logic [CW-1:0] att_cmd,
    input  logic [BW-1:0] att_ben,
    input  logic [DW-1:0] att_data,
    output logic          hit
);

    logic [BW-1:0] lane_ok;

    // One equality test per byte lane; a disabled lane always passes.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign lane_ok[g] = att_ben[g] |
                            (slot_data[8*g +: 8] == att_data[8*g +: 8]);
    end

    // Combine the lane results with the header fields.
    always_comb begin
        hit = slot_vld && (slot_addr == att_addr) && (slot_cmd == att_cmd) &&
              (slot_ben == att_ben) && (&lane_ok);
    end

endmodule

// File: rtl/dlyw_discard_tmr.sv
// Head-of-list discard timer. It loads when the head is seen delivered
// and counts down to zero. It expires one cycle after reaching zero
// unless that cycle collects the head.
// Assumes: head_done comes from registered state only.
module dlyw_discard_tmr #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_done,
    input  logic          collect,
    input  logic [TW-1:0] load_val,
    output logic          expire
);

    logic          run;
    logic [TW-1:0] cnt;

    // An expiry occurs only when the head is not collected in the same cycle.
    always_comb begin
        expire = run && (cnt == '0) && !collect;
    end

    // Load, count down, or stop the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (collect || expire) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end else if (head_done) begin
            run <= 1'b1;
            cnt <= load_val;
        end
    end

endmodule

// File: rtl/dlyw_store.sv
// Circular storage for the delayed writes. A head pointer marks the oldest
// entry, a tail pointer the next free slot, and an execute pointer the
// oldest undelivered entry.
// Assumes: push is never raised when full, and pop only when the head is
// delivered.
module dlyw_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int CW    = 4,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    in_addr,
    input  logic [CW-1:0]    in_cmd,
    input  logic [BW-1:0]    in_ben,
    input  logic [DW-1:0]    in_data,
    input  logic             pop,
    input  logic             cpl,
    output logic [DEPTH-1:0] slot_vld,
    output logic [DEPTH-1:0] slot_done,
    output logic [AW-1:0]    slot_addr [DEPTH],
    output logic [CW-1:0]    slot_cmd  [DEPTH],
    output logic [BW-1:0]    slot_ben  [DEPTH],
    output logic [DW-1:0]    slot_data [DEPTH],
    output logic [PW-1:0]    head_ptr,
    output logic             head_done,
    output logic             full,
    output logic [NW-1:0]    count,
    output logic             exec_valid,
    output logic [AW-1:0]    exec_addr,
    output logic [CW-1:0]    exec_cmd,
    output logic [BW-1:0]    exec_ben,
    output logic [DW-1:0]    exec_data
);

    logic [PW-1:0] tl_ptr;
    logic [PW-1:0] ex_ptr;
    logic          cpl_take;

    // Advance a pointer with wrap-around at DEPTH.
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Derived status of the list.
    always_comb begin
        head_done  = slot_vld[head_ptr] && slot_done[head_ptr];
        full       = (count == NW'(DEPTH));
        cpl_take   = cpl && slot_vld[ex_ptr] && !slot_done[ex_ptr];
        exec_valid = slot_vld[ex_ptr] && !slot_done[ex_ptr];
        exec_addr  = slot_addr[ex_ptr];
        exec_cmd   = slot_cmd[ex_ptr];
        exec_ben   = slot_ben[ex_ptr];
        exec_data  = slot_data[ex_ptr];
    end

    // Pointers, occupancy and per-slot flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            slot_done <= '0;
            head_ptr  <= '0;
            tl_ptr    <= '0;
            ex_ptr    <= '0;
            count     <= '0;
        end else begin
            if (push) begin
                slot_vld[tl_ptr]  <= 1'b1;
                slot_done[tl_ptr] <= 1'b0;
                tl_ptr            <= nxt(tl_ptr);
            end
            if (cpl_take) begin
                slot_done[ex_ptr] <= 1'b1;
                ex_ptr            <= nxt(ex_ptr);
            end
            if (pop) begin
                slot_vld[head_ptr] <= 1'b0;
                head_ptr           <= nxt(head_ptr);
            end
            count <= count + NW'(push) - NW'(pop);
        end
    end

    // Payload written at the tail; it needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tl_ptr] <= in_addr;
            slot_cmd[tl_ptr]  <= in_cmd;
            slot_ben[tl_ptr]  <= in_ben;
            slot_data[tl_ptr] <= in_data;
        end
    end

endmodule

// File: rtl/dlyw_queue_chk.sv
// Property checker for dlyw_queue, attached through the bind at the end
// of this file.
// Assumes: it is bound to dlyw_queue, whose signal names it uses.
module dlyw_queue_chk #(
    parameter int DEPTH = 4,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             att_valid,
    input logic             rsp_valid,
    input logic             rsp_retry,
    input logic             rsp_xfer,
    input logic             rsp_stop,
    input logic             serr_en,
    input logic             serr_pulse,
    input logic [DEPTH-1:0] hit_vec,
    input logic [NW-1:0]    q_count,
    input logic             push
);

    // R2: a response follows an attempt by exactly one cycle.
    a_r2_rsp_follows_att: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(att_valid));

    // R7: a transfer is never also a retry, and stop comes only with a transfer.
    a_r7_xfer_not_retry: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_xfer |-> (rsp_valid && !rsp_retry));
    a_r7_stop_with_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stop |-> rsp_xfer);

    // R4: at most one entry matches any attempt.
    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: the list never overflows.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q_count < NW'(DEPTH)));

    // R10: the error pulse needs the enable and lasts one cycle.
    a_r10_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> $past(serr_en));
    a_r10_serr_single: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |=> !serr_pulse);

endmodule

bind dlyw_queue dlyw_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .att_valid  (att_valid),
    .rsp_valid  (rsp_valid),
    .rsp_retry  (rsp_retry),
    .rsp_xfer   (rsp_xfer),
    .rsp_stop   (rsp_stop),
    .serr_en    (serr_en),
    .serr_pulse (serr_pulse),
    .hit_vec    (hit_vec),
    .q_count    (q_count),
    .push       (push)
);

// File: rtl/dlyw_queue.sv
// Delayed write queue top. It matches each attempt against the stored
// entries, queues new writes, releases delivered head completions with
// an optional disconnect, and ages out uncollected completions.
// Assumes: att_* is sampled on every cycle with att_valid high, and
// cpl_valid refers to the oldest undelivered entry.
module dlyw_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int CW    = 4,
    parameter int DW    = 32,
    parameter int TW    = 16,
    localparam int BW   = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          att_valid,
    input  logic [AW-1:0] att_addr,
    input  logic [CW-1:0] att_cmd,
    input  logic [BW-1:0] att_ben,
    input  logic [DW-1:0] att_data,
    input  logic          att_multi,
    input  logic          cpl_valid,
    input  logic [TW-1:0] discard_load,
    input  logic          serr_en,
    output logic          rsp_valid,
    output logic          rsp_retry,
    output logic          rsp_xfer,
    output logic          rsp_stop,
    output logic          serr_pulse,
    output logic          exec_valid,
    output logic [AW-1:0] exec_addr,
    output logic [CW-1:0] exec_cmd,
    output logic [BW-1:0] exec_ben,
    output logic [DW-1:0] exec_data
);
    import dlyw_pkg::*;

    logic [DEPTH-1:0] slot_vld;
    logic [DEPTH-1:0] slot_done;
    logic [AW-1:0]    slot_addr [DEPTH];
    logic [CW-1:0]    slot_cmd  [DEPTH];
    logic [BW-1:0]    slot_ben  [DEPTH];
    logic [DW-1:0]    slot_data [DEPTH];
    logic [PW-1:0]    head_ptr;
    logic             head_done;
    logic             full;
    logic [NW-1:0]    q_count;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    hit_idx;
    logic             expire;
    logic             push;
    logic             collect;
    dlyw_act_t        act;
    dlyw_rsp_t        rsp_q;

    // Entry storage and pointers.
    dlyw_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .in_addr    (att_addr),
        .in_cmd     (att_cmd),
        .in_ben     (att_ben),
        .in_data    (att_data),
        .pop        (collect || expire),
        .cpl        (cpl_valid),
        .slot_vld   (slot_vld),
        .slot_done  (slot_done),
        .slot_addr  (slot_addr),
        .slot_cmd   (slot_cmd),
        .slot_ben   (slot_ben),
        .slot_data  (slot_data),
        .head_ptr   (head_ptr),
        .head_done  (head_done),
        .full       (full),
        .count      (q_count),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .exec_cmd   (exec_cmd),
        .exec_ben   (exec_ben),
        .exec_data  (exec_data)
    );

    // One comparator per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        dlyw_slot_cmp #(.AW(AW), .CW(CW), .DW(DW)) u_cmp (
            .slot_vld  (slot_vld[s]),
            .slot_addr (slot_addr[s]),
            .slot_cmd  (slot_cmd[s]),
            .slot_ben  (slot_ben[s]),
            .slot_data (slot_data[s]),
            .att_addr  (att_addr),
            .att_cmd   (att_cmd),
            .att_ben   (att_ben),
            .att_data  (att_data),
            .hit       (hit_vec[s])
        );
    end

    // Head-of-list discard timer.
    dlyw_discard_tmr #(.TW(TW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_done (head_done),
        .collect   (collect),
        .load_val  (discard_load),
        .expire    (expire)
    );

    // Encode the matching slot (at most one is set).
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = PW'(i);
        end
    end

    // Decide what the attempt does to the list.
    always_comb begin
        act = ACT_NONE;
        if (att_valid) begin
            if (|hit_vec) begin
                act = (hit_idx == head_ptr && slot_done[hit_idx]) ? ACT_COLLECT : ACT_HOLD;
            end else if (!full) begin
                act = ACT_QUEUE;
            end else begin
                act = ACT_HOLD;
            end
        end
        push    = (act == ACT_QUEUE);
        collect = (act == ACT_COLLECT);
    end

    // Register the response and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= '0;
            serr_pulse <= 1'b0;
        end else begin
            rsp_q.vld   <= att_valid;
            rsp_q.retry <= att_valid && !collect;
            rsp_q.xfer  <= collect;
            rsp_q.stop  <= collect && att_multi;
            serr_pulse  <= expire && serr_en;
        end
    end

    // Drive the response ports.
    always_comb begin
        rsp_valid = rsp_q.vld;
        rsp_retry = rsp_q.retry;
        rsp_xfer  = rsp_q.xfer;
        rsp_stop  = rsp_q.stop;
    end

endmodule

// File: tb/dlyw_queue_test.sv
`timescale 1ns/1ps
module dlyw_queue_test;
    localparam int DEPTH = 4;
    localparam int AW = 32, CW = 4, DW = 32, TW = 16, BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          att_valid = 1'b0;
    logic [AW-1:0] att_addr = '0;
    logic [CW-1:0] att_cmd = '0;
    logic [BW-1:0] att_ben = '0;
    logic [DW-1:0] att_data = '0;
    logic          att_multi = 1'b0;
    logic          cpl_valid = 1'b0;
    logic [TW-1:0] discard_load = 16'd200;
    logic          serr_en = 1'b1;
    logic          rsp_valid, rsp_retry, rsp_xfer, rsp_stop, serr_pulse;
    logic          exec_valid;
    logic [AW-1:0] exec_addr;
    logic [CW-1:0] exec_cmd;
    logic [BW-1:0] exec_ben;
    logic [DW-1:0] exec_data;

    dlyw_queue #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DW(DW), .TW(TW)) uut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [AW-1:0] addr;
        logic [CW-1:0] cmd;
        logic [BW-1:0] ben;
        logic [DW-1:0] data;
        bit            done;
    } txn_t;

    txn_t m_q[$];
    bit   m_run;
    int   m_cnt;
    bit   e_rv, e_retry, e_xfer, e_stop, e_serr;
    int   m_hit;
    bit   m_collect, m_expire, m_marked;
    txn_t m_new;

    function automatic bit same_txn(input txn_t t);
        if (t.addr != att_addr || t.cmd != att_cmd || t.ben != att_ben) return 0;
        for (int b = 0; b < BW; b++)
            if (!att_ben[b] && t.data[8*b +: 8] != att_data[8*b +: 8]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_run = 0; m_cnt = 0;
            e_rv = 0; e_retry = 0; e_xfer = 0; e_stop = 0; e_serr = 0;
        end else begin
            m_hit = -1;
            if (att_valid)
                for (int k = 0; k < m_q.size(); k++)
                    if (m_hit < 0 && same_txn(m_q[k])) m_hit = k;
            m_collect = att_valid && (m_hit == 0) && m_q[0].done;
            m_expire  = m_run && (m_cnt == 0) && !m_collect;
            if (m_collect || m_expire) m_run = 0;
            else if (m_run) m_cnt--;
            else if (m_q.size() > 0 && m_q[0].done) begin m_run = 1; m_cnt = int'(discard_load); end
            e_rv = att_valid;
            e_xfer = m_collect;
            e_retry = att_valid && !m_collect;
            e_stop = m_collect && att_multi;
            e_serr = m_expire && serr_en;
            if (cpl_valid) begin
                m_marked = 0;
                for (int k = 0; k < m_q.size(); k++)
                    if (!m_marked && !m_q[k].done) begin m_q[k].done = 1; m_marked = 1; end
            end
            if (att_valid && m_hit < 0 && m_q.size() < DEPTH) begin
                m_new.addr = att_addr; m_new.cmd = att_cmd; m_new.ben = att_ben;
                m_new.data = att_data; m_new.done = 0;
                m_q.push_back(m_new);
            end
            if (m_collect || m_expire) void'(m_q.pop_front());
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int ex;
            ex = -1;
            for (int k = 0; k < m_q.size(); k++) if (ex < 0 && !m_q[k].done) ex = k;
            check("R2 rsp_valid", 64'(rsp_valid), 64'(e_rv));
            check("R4 rsp_retry", 64'(rsp_retry), 64'(e_retry));
            check("R7 rsp_xfer", 64'(rsp_xfer), 64'(e_xfer));
            check("R7 rsp_stop", 64'(rsp_stop), 64'(e_stop));
            check("R10 serr_pulse", 64'(serr_pulse), 64'(e_serr));
            check("R6 exec_valid", 64'(exec_valid), 64'(ex >= 0));
            if (ex >= 0) begin
                check("R6 exec_addr", 64'(exec_addr), 64'(m_q[ex].addr));
                check("R6 exec_cmd", 64'(exec_cmd), 64'(m_q[ex].cmd));
                check("R6 exec_ben", 64'(exec_ben), 64'(m_q[ex].ben));
                check("R6 exec_data", 64'(exec_data), 64'(m_q[ex].data));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic attempt(input logic [AW-1:0] a, input logic [CW-1:0] c,
                           input logic [BW-1:0] be, input logic [DW-1:0] d, input bit multi);
        @(negedge clk);
        att_valid = 1; att_addr = a; att_cmd = c; att_ben = be; att_data = d; att_multi = multi;
        @(negedge clk);
        att_valid = 0;
    endtask

    task automatic complete_one();
        @(negedge clk); cpl_valid = 1;
        @(negedge clk); cpl_valid = 0;
    endtask

    task automatic serr_window(input string tag, input int n, input bit hit_last);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(tag, 64'(serr_pulse), 64'(hit_last && i == n));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R1..R11 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, during reset and just after release.
        check("R1 rsp_valid", 64'(rsp_valid), 0);
        check("R1 serr_pulse", 64'(serr_pulse), 0);
        rst_n = 1;
        check("R1 exec_valid", 64'(exec_valid), 0);
        check("R1 rsp_xfer", 64'(rsp_xfer), 0);

        // R2: first attempt is retried and queued. A: lanes 0 and 1 enabled.
        attempt(32'h100, 4'h7, 4'b1100, 32'hA3A2A1A0, 0);
        check("R2 retry", 64'(rsp_retry), 1);
        check("R2 exec_addr", 64'(exec_addr), 64'h100);
        check("R2 exec_data", 64'(exec_data), 64'hA3A2A1A0);
        // R5: differs only in disabled lane 3: matches, no entry added.
        attempt(32'h100, 4'h7, 4'b1100, 32'h55A2A1A0, 0);
        check("R5 retry masked", 64'(rsp_retry), 1);
        // R5: differs in enabled lane 0: a new entry.
        attempt(32'h100, 4'h7, 4'b1100, 32'hA3A2A155, 0);
        complete_one();
        check("R5 second entry data", 64'(exec_data), 64'hA3A2A155);
        // R7: collect delivered head with a multi-DWORD request.
        attempt(32'h100, 4'h7, 4'b1100, 32'hA3A2A1A0, 1);
        check("R7 xfer", 64'(rsp_xfer), 1);
        check("R7 stop", 64'(rsp_stop), 1);
        check("R7 no retry", 64'(rsp_retry), 0);
        // R4: undelivered repeat is retried.
        attempt(32'h100, 4'h7, 4'b1100, 32'hA3A2A155, 0);
        check("R4 retry", 64'(rsp_retry), 1);
        check("R4 xfer", 64'(rsp_xfer), 0);
        // Fill the list: A', B, C, D.
        attempt(32'h200, 4'h6, 4'b0000, 32'h0000_0B0B, 0);
        attempt(32'h300, 4'h6, 4'b0000, 32'h0000_0C0C, 0);
        attempt(32'h400, 4'h6, 4'b0000, 32'h0000_0D0D, 0);
        // R3: a fifth write is retried and not stored.
        attempt(32'h500, 4'h6, 4'b0000, 32'h0000_0E0E, 0);
        check("R3 retry when full", 64'(rsp_retry), 1);
        complete_one(); complete_one(); complete_one();
        check("R6 fifo order", 64'(exec_addr), 64'h400);
        complete_one();
        check("R3 fifth not stored", 64'(exec_valid), 0);
        // R8: delivered but not at the head: retried.
        attempt(32'h300, 4'h6, 4'b0000, 32'h0000_0C0C, 0);
        check("R8 retry", 64'(rsp_retry), 1);
        check("R8 no xfer", 64'(rsp_xfer), 0);
        discard_load = 16'd5;
        attempt(32'h100, 4'h7, 4'b1100, 32'hA3A2A155, 0);
        check("R7 xfer single", 64'(rsp_xfer), 1);
        check("R7 no stop single", 64'(rsp_stop), 0);
        // R9: B ages out L+2 cycles after the collection (load edge + L+1).
        serr_window("R9 discard timing", 7, 1);
        // R11: the timer restarts for C.
        serr_window("R11 restart timing", 7, 1);
        serr_en = 0;
        // R10: no pulse when disabled, while D is discarded.
        serr_window("R10 disabled", 7, 0);
        repeat (2) @(negedge clk);
        attempt(32'h400, 4'h6, 4'b0000, 32'h0000_0D0D, 0);
        check("R9 D was discarded", 64'(exec_valid), 1);
        check("R9 D requeued", 64'(exec_addr), 64'h400);
        serr_en = 1;

        // Random traffic from a small pool of writes.
        begin
            logic [DW-1:0] pdata [6];
            logic [BW-1:0] pben [6];
            for (int p = 0; p < 6; p++) begin
                pdata[p] = $urandom;
                pben[p] = 4'(p * 5);
            end
            for (int cyc = 0; cyc < 4000; cyc++) begin
                int p, r;
                @(negedge clk);
                p = $urandom_range(0, 5);
                r = $urandom_range(0, 99);
                att_valid = (r < 45);
                att_addr = 32'h1000 + 32'(p) * 32'h40;
                att_cmd = p[0] ? 4'h7 : 4'hB;
                att_ben = pben[p];
                att_data = pdata[p];
                if (r < 8) att_data = att_data ^ (32'hFF << (8 * $urandom_range(0, 3)));
                att_multi = $urandom_range(0, 1) == 1;
                cpl_valid = ($urandom_range(0, 99) < 25);
                if ($urandom_range(0, 99) < 3) discard_load = 16'($urandom_range(0, 12));
                if ($urandom_range(0, 99) < 2) serr_en = ~serr_en;
            end
            @(negedge clk);
            att_valid = 0; cpl_valid = 0;
            repeat (40) @(negedge clk);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule